// File: doc/BRIEF.md
# Memory Chip-Enable Gating Controller

This block sits between a processor's active-low chip-enable and a battery-backed memory. While the system is healthy it passes the chip-enable straight through, with no register in the path. When the supervisor reports that reset has asserted, the block stops passing the enable. This keeps a failing supply from turning a half-driven bus cycle into a corrupt write.

The decision is made from the level of the incoming enable in the first cycle of the reset event. An idle (high) enable blocks the output at once, and the output stays high until the event ends. An active (low) enable means an access is already under way. The output is then held low for a fixed number of clock ticks so that access can finish, and after that it is forced high for the rest of the event. Battery-backup mode always disconnects the input and drives the output high. When the reset event clears, the output again follows the input in the same cycle. The logic's own synchronous reset leaves the gate blocked.

Top module: `ce_gate_ctrl`

## Requirements
- R1: With `rst`, `rst_event` and `batt_mode` all low, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock latency.
- R2: If `ce_in_n` is 1 in the first cycle that `rst_event` is high, `ce_out_n` is 1 in that cycle and in every later cycle of the event, whatever `ce_in_n` does.
- R3: If `ce_in_n` is 0 in the first cycle that `rst_event` is high, `ce_out_n` is 0 for exactly `HOLD_TICKS` cycles, counting that first cycle, whatever `ce_in_n` does during the hold.
- R4: Once the hold of R3 has run out, `ce_out_n` is 1 for the rest of the event, whatever `ce_in_n` does.
- R5: While `batt_mode` is 1, `ce_out_n` is 1 in the same cycle. If `rst_event` is still high after `batt_mode` falls, the output stays 1 and no new hold starts.
- R6: In the cycle that `rst_event` goes low, with `batt_mode` low, `ce_out_n` follows `ce_in_n` again.
- R7: While `rst` is 1, `ce_out_n` is 1. If `rst_event` is already high when `rst` is released, the output stays 1 until the event ends.
- R8: If `rst_event` drops during a hold, the output follows the input from that cycle on. A later event captures the input afresh and grants a full hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one tick of the hold counter per cycle |
| rst | input | 1 | Synchronous active-high reset of the gating logic |
| ce_in_n | input | 1 | Incoming active-low chip-enable from the processor |
| rst_event | input | 1 | High while the supervisor's reset output is asserted |
| batt_mode | input | 1 | High while the memory runs from the backup battery |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |

## Verification
The properties assume that `rst_event`, `batt_mode` and `ce_in_n` are synchronous to `clk` and settle once per cycle. They also assume the hold parameter is at least two ticks, so a low capture cycle is always followed by at least one more held-low cycle. The bench changes every input only just after a falling edge and samples the output one nanosecond later. It builds the hold from a small parameter so that several full holds fit into a short run. It also drives event edges, battery entry and exit, and logic resets at each phase of the hold, including one at the last held-low cycle.

// File: rtl/ceg_pkg.sv
`timescale 1ns/1ps
package ceg_pkg;

    // Gate phases: straight pass, grace hold (output low), blocked (output high)
    typedef enum logic [1:0] {
        GATE_PASS  = 2'd0,
        GATE_HOLD  = 2'd1,
        GATE_BLOCK = 2'd2
    } gate_state_e;

    // Synchronous view of the block's control inputs
    typedef struct packed {
        logic ce_n;   // incoming active-low enable
        logic evt;    // reset event active
        logic batt;   // battery-backup mode
    } gate_in_s;

    // Inactive level of an active-low enable
    localparam logic CE_IDLE = 1'b1;

    // Input path is cut off regardless of phase
    function automatic logic path_cut(input gate_in_s i);
        return i.batt;
    endfunction

    // Capture decision taken in the first cycle of an event
    function automatic logic access_in_flight(input gate_in_s i);
        return i.evt && !i.batt && (i.ce_n == 1'b0);
    endfunction

    // Output level for a phase while an event is active
    function automatic logic event_level(input gate_state_e s, input logic ce_n);
        case (s)
            GATE_PASS:  return ce_n;     // capture cycle: the sampled level itself
            GATE_HOLD:  return 1'b0;     // grace period for the running access
            default:    return CE_IDLE;  // blocked
        endcase
    endfunction

endpackage

// File: rtl/ceg_hold_timer.sv
`timescale 1ns/1ps
module ceg_hold_timer #(
    parameter int HOLD_TICKS = 2400
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int CW = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= LOAD_VAL;
        end else if (run && (remain_q != '0)) begin
            remain_q <= remain_q - ONE;
        end
    end

    // Final held-low cycle in the hold phase
    assign last = run && (remain_q == ONE);

endmodule

// File: rtl/ceg_state_ctrl.sv
`timescale 1ns/1ps
module ceg_state_ctrl
    import ceg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  gate_in_s    in_s,
    input  logic        hold_last,
    output gate_state_e state,
    output logic        hold_load,
    output logic        hold_run
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (path_cut(in_s)) begin
            state_d = GATE_BLOCK;
        end else if (!in_s.evt) begin
            state_d = GATE_PASS;
        end else begin
            case (state_q)
                GATE_PASS:  state_d = access_in_flight(in_s) ? GATE_HOLD : GATE_BLOCK;
                GATE_HOLD:  state_d = hold_last ? GATE_BLOCK : GATE_HOLD;
                default:    state_d = GATE_BLOCK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_BLOCK;
        end else begin
            state_q <= state_d;
        end
    end

    assign state     = state_q;
    assign hold_load = (state_q == GATE_PASS) && access_in_flight(in_s);
    assign hold_run  = (state_q == GATE_HOLD);

endmodule

// File: rtl/ceg_out_mux.sv
`timescale 1ns/1ps
module ceg_out_mux
    import ceg_pkg::*;
(
    input  logic        rst,
    input  gate_in_s    in_s,
    input  gate_state_e state,
    output logic        ce_out_n
);
    always_comb begin
        if (rst || path_cut(in_s)) begin
            ce_out_n = CE_IDLE;
        end else if (!in_s.evt) begin
            ce_out_n = in_s.ce_n;
        end else begin
            ce_out_n = event_level(state, in_s.ce_n);
        end
    end

endmodule

// File: rtl/ce_gate_ctrl.sv
`timescale 1ns/1ps
module ce_gate_ctrl
    import ceg_pkg::*;
#(
    parameter int HOLD_TICKS = 2400
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_in_n,
    input  logic rst_event,
    input  logic batt_mode,
    output logic ce_out_n
);
    gate_in_s    in_s;
    gate_state_e state;
    logic        hold_load;
    logic        hold_run;
    logic        hold_last;

    assign in_s = '{ce_n: ce_in_n, evt: rst_event, batt: batt_mode};

    ceg_state_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_s      (in_s),
        .hold_last (hold_last),
        .state     (state),
        .hold_load (hold_load),
        .hold_run  (hold_run)
    );

    ceg_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (hold_load),
        .run  (hold_run),
        .last (hold_last)
    );

    ceg_out_mux u_mux (
        .rst      (rst),
        .in_s     (in_s),
        .state    (state),
        .ce_out_n (ce_out_n)
    );

endmodule

// File: rtl/ceg_gate_checker.sv
`timescale 1ns/1ps
module ceg_gate_checker #(
    parameter int HOLD_TICKS = 2400
) (
    input logic clk,
    input logic rst,
    input logic ce_in_n,
    input logic rst_event,
    input logic batt_mode,
    input logic ce_out_n
);
    logic        prev_ok, prev_evt, prev_out, prev_batt;
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ok   <= 1'b0;
            prev_evt  <= 1'b0;
            prev_out  <= 1'b1;
            prev_batt <= 1'b0;
            low_run   <= '0;
        end else begin
            prev_ok   <= 1'b1;
            prev_evt  <= rst_event;
            prev_out  <= ce_out_n;
            prev_batt <= batt_mode;
            low_run   <= (rst_event && !batt_mode && !ce_out_n) ? low_run + 32'd1 : 32'd0;
        end
    end

    // R1, R6: transparent path when nothing blocks it
    p_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (!rst_event && !batt_mode) |-> (ce_out_n == ce_in_n));

    // R2, R4: once high inside an event, stays high
    p_stay_high_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && prev_evt && prev_out && rst_event) |-> ce_out_n);

    // R3: a low capture is followed by a held-low cycle
    p_grace_start_r3: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !prev_evt && !prev_batt && rst_event && !batt_mode && !ce_out_n)
        |=> (!rst_event || batt_mode || !ce_out_n));

    // R3, R4: held-low run inside an event never exceeds the hold
    p_grace_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (rst_event && !ce_out_n) |-> (low_run < 32'(HOLD_TICKS)));

    // R5: battery mode forces the idle level
    p_batt_idle_r5: assert property (@(posedge clk) disable iff (rst)
        batt_mode |-> ce_out_n);

    // R7: logic reset leaves the gate blocked
    always @(posedge clk) begin
        if (rst) begin
            a_reset_idle_r7: assert (ce_out_n == 1'b1);
        end
    end

endmodule

bind ce_gate_ctrl ceg_gate_checker #(.HOLD_TICKS(HOLD_TICKS)) u_chk (.*);

// File: tb/ce_gate_ctrl_test.sv
`timescale 1ns/1ps
module ce_gate_ctrl_test;
    localparam int HOLD = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_in_n = 1'b1;
    logic rst_event = 1'b0;
    logic batt_mode = 1'b0;
    logic ce_out_n;

    int checks = 0;
    int fails  = 0;
    int m_st   = 2;   // 0 pass, 1 hold, 2 blocked
    int m_left = 0;

    always #2.5 clk = ~clk;

    ce_gate_ctrl #(.HOLD_TICKS(HOLD)) uut (
        .clk       (clk),
        .rst       (rst),
        .ce_in_n   (ce_in_n),
        .rst_event (rst_event),
        .batt_mode (batt_mode),
        .ce_out_n  (ce_out_n)
    );

    function automatic logic model_out();
        if (rst || batt_mode) return 1'b1;
        if (!rst_event)       return ce_in_n;
        if (m_st == 0)        return ce_in_n;
        if (m_st == 1)        return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_tick();
        if (rst || batt_mode) m_st = 2;
        else if (!rst_event)  m_st = 0;
        else if (m_st == 0) begin
            if (ce_in_n) m_st = 2;
            else begin m_st = 1; m_left = HOLD - 1; end
        end else if (m_st == 1) begin
            if (m_left == 1) m_st = 2;
            else m_left = m_left - 1;
        end
    endtask

    task automatic check(input logic exp, input string tag);
        checks++;
        if (ce_out_n !== exp) begin
            fails++;
            $display("FAIL %s: ce_out_n=%b expected %b at %0t", tag, ce_out_n, exp, $time);
        end
    endtask

    task automatic step(input logic ce, input logic evt, input logic batt,
                        input logic rs, input string tag);
        @(negedge clk);
        ce_in_n = ce; rst_event = evt; batt_mode = batt; rst = rs;
        #1;
        check(model_out(), tag);
        model_tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog (all requirements): actual still running, expected finished");
        summary();
        $finish;
    end

    initial begin
        int lows;
        // R7: reset state with input toggling
        for (int i = 0; i < 4; i++) step(i[0], 1'b0, 1'b0, 1'b1, "R7 reset");
        check(1'b1, "R7 reset idle");

        // R1: pass-through on several patterns
        for (int i = 0; i < 12; i++) step((i % 3) == 0, 1'b0, 1'b0, 1'b0, "R1 pass");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1 pass low");
        check(1'b0, "R1 direct low");

        // R2: idle at capture, then toggles ignored
        step(1'b1, 1'b1, 1'b0, 1'b0, "R2 capture high");
        for (int i = 0; i < 30; i++) step(i[0], 1'b1, 1'b0, 1'b0, "R2 blocked");
        check(1'b1, "R2 blocked idle");
        // R6: release follows input in same cycle
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6 release");
        check(1'b0, "R6 release low");
        for (int i = 0; i < 4; i++) step(i[0], 1'b0, 1'b0, 1'b0, "R6 pass");

        // R3/R4: low at capture, full hold then blocked
        lows = 0;
        for (int i = 0; i < HOLD + 20; i++) begin
            step((i == 0) ? 1'b0 : i[1], 1'b1, 1'b0, 1'b0, "R3 hold");
            if (ce_out_n == 1'b0) lows++;
        end
        checks++;
        if (lows != HOLD) begin
            fails++;
            $display("FAIL R3 hold length: actual %0d expected %0d", lows, HOLD);
        end
        step(1'b0, 1'b1, 1'b0, 1'b0, "R4 after hold");
        check(1'b1, "R4 blocked after hold");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6 release after hold");

        // R8: drop during hold, then fresh event
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R8 partial hold");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R8 drop");
        check(1'b1, "R8 follows high");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8 follows low");
        lows = 0;
        for (int i = 0; i < HOLD + 6; i++) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, "R8 fresh hold");
            if (ce_out_n == 1'b0) lows++;
        end
        checks++;
        if (lows != HOLD) begin
            fails++;
            $display("FAIL R8 fresh hold length: actual %0d expected %0d", lows, HOLD);
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, "R6 release");

        // R5: battery mode in pass, in hold, and exit with event still high
        step(1'b0, 1'b0, 1'b1, 1'b0, "R5 batt pass");
        check(1'b1, "R5 batt idle");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R5 batt exit pass");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5 hold before batt");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R5 batt in hold");
        check(1'b1, "R5 batt cuts hold");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5 batt exit in event");
        check(1'b1, "R5 no new hold");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 release");

        // Last held-low cycle then drop (boundary of R3/R8)
        for (int i = 0; i < HOLD; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R3 boundary");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R8 drop at boundary");
        check(1'b0, "R8 boundary follows");

        // R7: logic reset with event high, release while event persists
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R7 reset in event");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R7 after reset in event");
        check(1'b1, "R7 stays blocked");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7 event end");
        check(1'b0, "R7 resumes");

        summary();
        $finish;
    end

endmodule